// File: doc/BRIEF.md
# Bit-Sliced Integer ALU With Set-Less-Than

This block is a purely combinational integer arithmetic-logic unit. It is built from a row of identical one-bit slices that share one ripple carry chain. Each slice can complement its A bit and its B bit. It has an AND gate, an OR gate and a full adder, and a four-way selector picks the slice output. The selector's fourth input is a "less" bit. Two operand-inversion controls and a two-bit selector are enough to give AND, OR, NOR, addition, subtraction and a signed set-less-than.

The B-negate control does two jobs. It complements every B bit, and it supplies the carry into the lowest slice, which gives two's-complement subtraction. NOR comes from complementing both operands and selecting the AND gate. For set-less-than, the adder sum bit of the top slice is routed back into the less input of bit 0, and every other slice sees a less input of 0. Equality and inequality tests use the subtract setting and read the zero flag. The overflow flag and the carry-out come from the adder, and they are driven for every operation.

Top module: `bitslice_alu`

## Requirements
- R1: With select 00 and neither inversion control set, result equals A AND B.
- R2: With select 01 and neither inversion control set, result equals A OR B.
- R3: With select 10, B-negate 0 and A-invert 0, result equals (A + B) mod 2^WIDTH and carryOut equals bit WIDTH of the full sum.
- R4: With select 10, B-negate 1 and A-invert 0, result equals (A - B) mod 2^WIDTH and carryOut is 1 exactly when A >= B as unsigned numbers.
- R5: With select 00, B-negate 1 and A-invert 1, result equals NOT (A OR B).
- R6: With select 11, result bits WIDTH-1 down to 1 are 0 and result bit 0 is the top sum bit of the adder. With B-negate 1 this is the raw sign of A - B, with no correction for overflow.
- R7: zero is 1 exactly when every result bit is 0, for every operation.
- R8: overflow is 1 exactly when the carry into the top slice differs from the carry out of it. For the add setting, this is signed overflow.
- R9: carryOut is the carry out of the top slice for every control setting, including logic operations.
- R10: A-invert complements A and B-negate complements B ahead of the gates and the adder, and B-negate is also the carry into bit 0. This holds for every select value, including combinations that name no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| opSel | input | 2 | Slice output select: 00 AND, 01 OR, 10 adder sum, 11 less input |
| bNegate | input | 1 | Complement B and set the carry into bit 0 |
| aInvert | input | 1 | Complement A |
| result | output | WIDTH | Selected output of all slices |
| zero | output | 1 | Result is all zeros |
| overflow | output | 1 | Carry into top slice differs from carry out of it |
| carryOut | output | 1 | Carry out of the top slice |

## Verification
The bench builds two copies of the block: one at the default WIDTH of 32 and one at WIDTH 4. At WIDTH 4, every pair of operands can be applied under all sixteen control combinations. This covers each carry and overflow boundary, as well as set-less-than results where the raw sign and the true signed order disagree. The 32-bit copy takes directed extreme operands, such as the most negative value, all ones, and equal operands. It also takes pseudo-random operands under the same control sweep, so the full-length carry chain and the wide zero detect are exercised.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sliceSel_t;

  // Strobes that the control hands to the slice datapath.
  typedef struct packed {
    sliceSel_t sel;
    logic      aInvert;
    logic      bInvert;
    logic      carrySeed;
  } aluStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [1:0]  opSel,
  input  logic        bNegate,
  input  logic        aInvert,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes.sel       = sliceSel_t'(opSel);
    strobes.aInvert   = aInvert;
    strobes.bInvert   = bNegate;
    // one's complement plus this seed gives the two's complement of B
    strobes.carrySeed = bNegate;
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  aluStrobes_t strobes,
  input  logic        aBit,
  input  logic        bBit,
  input  logic        carryIn,
  input  logic        lessIn,
  output logic        resBit,
  output logic        sumBit,
  output logic        carryOutBit
);

  logic aEff;
  logic bEff;
  logic halfSum;

  assign aEff        = aBit ^ strobes.aInvert;
  assign bEff        = bBit ^ strobes.bInvert;
  assign halfSum     = aEff ^ bEff;
  assign sumBit      = halfSum ^ carryIn;
  assign carryOutBit = (aEff & bEff) | (carryIn & halfSum);

  always_comb begin
    unique case (strobes.sel)
      SEL_AND:  resBit = aEff & bEff;
      SEL_OR:   resBit = aEff | bEff;
      SEL_SUM:  resBit = sumBit;
      SEL_LESS: resBit = lessIn;
      default:  resBit = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
)(
  input  aluStrobes_t      strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carryOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carryChain;
  logic [WIDTH-1:0] sumVec;
  logic             setBit;

  assign carryChain[0] = strobes.carrySeed;
  assign setBit        = sumVec[MSB];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic lessIn;
    if (i == 0) begin : g_lsb
      assign lessIn = setBit;
    end else begin : g_upper
      assign lessIn = 1'b0;
    end

    alu_slice u_slice (
      .strobes     (strobes),
      .aBit        (opA[i]),
      .bBit        (opB[i]),
      .carryIn     (carryChain[i]),
      .lessIn      (lessIn),
      .resBit      (result[i]),
      .sumBit      (sumVec[i]),
      .carryOutBit (carryChain[i+1])
    );
  end

  assign zero     = ~(|result);
  assign carryOut = carryChain[WIDTH];
  assign overflow = carryChain[MSB] ^ carryChain[WIDTH];

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
)(
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [1:0]       opSel,
  input  logic             bNegate,
  input  logic             aInvert,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carryOut
);

  aluStrobes_t strobes;

  alu_ctrl u_ctrl (
    .opSel   (opSel),
    .bNegate (bNegate),
    .aInvert (aInvert),
    .strobes (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .zero     (zero),
    .overflow (overflow),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int WIDTH = 32
)(
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [1:0]       opSel,
  input logic             bNegate,
  input logic             aInvert,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             overflow,
  input logic             carryOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wideSum;
  logic [WIDTH:0] wideDiff;
  logic           plainCtl;
  logic           subCtl;

  assign wideSum  = {1'b0, opA} + {1'b0, opB};
  assign wideDiff = {1'b0, opA} + {1'b0, ~opB} + {{WIDTH{1'b0}}, 1'b1};
  assign plainCtl = !aInvert && !bNegate;
  assign subCtl   = !aInvert && bNegate;

  always_comb begin
    AST_ZERO_FLAG: assert (zero == (result == '0));                                  // R7
    AST_AND_RESULT: assert (!(opSel == 2'b00 && plainCtl) || result == (opA & opB)); // R1
    AST_OR_RESULT: assert (!(opSel == 2'b01 && plainCtl) || result == (opA | opB));  // R2
    AST_NOR_RESULT: assert (!(opSel == 2'b00 && aInvert && bNegate) || result == ~(opA | opB)); // R5
    AST_ADD_RESULT: assert (!(opSel == 2'b10 && plainCtl) || {carryOut, result} == wideSum);    // R3
    AST_SUB_RESULT: assert (!(opSel == 2'b10 && subCtl) || (result == wideDiff[MSB:0] && carryOut == (opA >= opB))); // R4
    AST_LESS_UPPER_CLEAR: assert (opSel != 2'b11 || result[MSB:1] == '0);            // R6
    AST_ADD_OVERFLOW: assert (!(opSel == 2'b10 && plainCtl) || overflow == ((opA[MSB] == opB[MSB]) && (result[MSB] != opA[MSB]))); // R8
  end

endmodule

bind bitslice_alu alu_checker #(.WIDTH(WIDTH)) u_alu_checker (
  .opA      (opA),
  .opB      (opB),
  .opSel    (opSel),
  .bNegate  (bNegate),
  .aInvert  (aInvert),
  .result   (result),
  .zero     (zero),
  .overflow (overflow),
  .carryOut (carryOut)
);

// File: tb/test_bitslice_alu.sv
module test_bitslice_alu;

  localparam int CLK_PERIOD = 10;
  localparam int WIDE = 32;
  localparam int NARROW = 4;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [1:0]        opSel;
  logic              bNegate;
  logic              aInvert;
  logic [WIDE-1:0]   wA, wB, wRes;
  logic              wZero, wOvf, wCarry;
  logic [NARROW-1:0] nA, nB, nRes;
  logic              nZero, nOvf, nCarry;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;

  bitslice_alu #(.WIDTH(WIDE)) i_bitslice_alu (
    .opA(wA), .opB(wB), .opSel(opSel), .bNegate(bNegate), .aInvert(aInvert),
    .result(wRes), .zero(wZero), .overflow(wOvf), .carryOut(wCarry)
  );

  bitslice_alu #(.WIDTH(NARROW)) i_bitslice_alu_w4 (
    .opA(nA), .opB(nB), .opSel(opSel), .bNegate(bNegate), .aInvert(aInvert),
    .result(nRes), .zero(nZero), .overflow(nOvf), .carryOut(nCarry)
  );

  // Arithmetic model derived from the requirements.
  function automatic void refModel(input int n, input logic [63:0] a, input logic [63:0] b,
                                   input logic [1:0] sel, input logic bn, input logic ai,
                                   output logic [63:0] res, output logic z,
                                   output logic ov, output logic co);
    logic [63:0] mask, lowMask, ea, eb, full, lower;
    mask    = (64'd1 << n) - 64'd1;
    lowMask = (64'd1 << (n - 1)) - 64'd1;
    ea      = (ai ? ~a : a) & mask;                 // R10
    eb      = (bn ? ~b : b) & mask;
    full    = ea + eb + {63'd0, bn};
    lower   = (ea & lowMask) + (eb & lowMask) + {63'd0, bn};
    co      = full[n];                              // R9
    ov      = lower[n-1] ^ full[n];                 // R8
    case (sel)
      2'b00:   res = ea & eb;
      2'b01:   res = ea | eb;
      2'b10:   res = full & mask;
      default: res = {63'd0, full[n-1]};            // R6 raw sign
    endcase
    z = (res == 64'd0);                             // R7
  endfunction

  function automatic string tagFor(input logic [1:0] sel, input logic bn, input logic ai);
    if (sel == 2'b00 && !bn && !ai) return "R1";
    if (sel == 2'b00 && bn && ai)   return "R5";
    if (sel == 2'b01 && !bn && !ai) return "R2";
    if (sel == 2'b10 && !bn && !ai) return "R3";
    if (sel == 2'b10 && bn && !ai)  return "R4";
    if (sel == 2'b11)               return "R6";
    return "R10";
  endfunction

  task automatic compareOne(input int n, input logic [63:0] a, input logic [63:0] b,
                            input logic [63:0] actRes, input logic actZ,
                            input logic actOv, input logic actCo);
    logic [63:0] eRes;
    logic eZ, eOv, eCo;
    string tag;
    refModel(n, a, b, opSel, bNegate, aInvert, eRes, eZ, eOv, eCo);
    tag = tagFor(opSel, bNegate, aInvert);
    vectors++;
    if (actRes !== eRes) begin
      miscompares++;
      $display("FAIL %s w%0d a=%h b=%h result act=%h exp=%h", tag, n, a, b, actRes, eRes);
    end
    if (actZ !== eZ) begin
      miscompares++;
      $display("FAIL R7 w%0d a=%h b=%h zero act=%b exp=%b", n, a, b, actZ, eZ);
    end
    if (actOv !== eOv) begin
      miscompares++;
      $display("FAIL R8 w%0d a=%h b=%h overflow act=%b exp=%b", n, a, b, actOv, eOv);
    end
    if (actCo !== eCo) begin
      miscompares++;
      $display("FAIL R9 w%0d a=%h b=%h carryOut act=%b exp=%b", n, a, b, actCo, eCo);
    end
  endtask

  // Drive on the rising edge, compare both copies on the falling edge.
  task automatic applyVec(input logic [1:0] sel, input logic bn, input logic ai,
                          input logic [WIDE-1:0] a32, input logic [WIDE-1:0] b32,
                          input logic [NARROW-1:0] a4, input logic [NARROW-1:0] b4);
    @(posedge clk);
    opSel = sel; bNegate = bn; aInvert = ai;
    wA = a32; wB = b32; nA = a4; nB = b4;
    @(negedge clk);
    compareOne(WIDE, {32'd0, wA}, {32'd0, wB}, {32'd0, wRes}, wZero, wOvf, wCarry);
    compareOne(NARROW, {60'd0, nA}, {60'd0, nB}, {60'd0, nRes}, nZero, nOvf, nCarry);
  endtask

  initial begin
    opSel = 2'b00; bNegate = 1'b0; aInvert = 1'b0;
    wA = '0; wB = '0; nA = '0; nB = '0;

    // Idle state: all-zero inputs give AND of zeros, zero flag set (R1, R7)
    applyVec(2'b00, 1'b0, 1'b0, 32'h0, 32'h0, 4'h0, 4'h0);
    // R1 / R2 / R5 bit patterns
    applyVec(2'b00, 1'b0, 1'b0, 32'hF0F0_A5A5, 32'hFF00_0FF0, 4'hC, 4'hA);
    applyVec(2'b01, 1'b0, 1'b0, 32'hF0F0_A5A5, 32'h0F00_0FF0, 4'h8, 4'h1);
    applyVec(2'b00, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0000, 4'h0, 4'h0);
    applyVec(2'b00, 1'b1, 1'b1, 32'h1234_0000, 32'h0000_5678, 4'h5, 4'hA);
    // R3 / R8: signed overflow at the positive limit, wrap of two negatives
    applyVec(2'b10, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 4'h7, 4'h1);
    applyVec(2'b10, 1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000, 4'h8, 4'h8);
    applyVec(2'b10, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 4'hF, 4'h1);
    // R4 / R7: equal operands give zero, borrow clears carry
    applyVec(2'b10, 1'b1, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'h9, 4'h9);
    applyVec(2'b10, 1'b1, 1'b0, 32'h0000_0003, 32'h0000_0005, 4'h3, 4'h5);
    applyVec(2'b10, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_0001, 4'h8, 4'h1);
    // R6: ordinary less, and the uncorrected case where the sign lies
    applyVec(2'b11, 1'b1, 1'b0, 32'h0000_0005, 32'h0000_0007, 4'h5, 4'h7);
    applyVec(2'b11, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_0001, 4'h8, 4'h1);
    applyVec(2'b11, 1'b1, 1'b0, 32'h0000_0007, 32'h0000_0005, 4'h7, 4'h5);
    // R10: select 11 without negate, OR with A inverted
    applyVec(2'b11, 1'b0, 1'b0, 32'h4000_0000, 32'h4000_0000, 4'h4, 4'h4);
    applyVec(2'b01, 1'b0, 1'b1, 32'hFFFF_0000, 32'h0000_00FF, 4'hF, 4'h0);

    // Full sweep: every control combination, every narrow operand pair.
    for (int ctl = 0; ctl < 16; ctl++) begin
      for (int a = 0; a < (1 << NARROW); a++) begin
        for (int b = 0; b < (1 << NARROW); b++) begin
          applyVec(ctl[1:0], ctl[2], ctl[3], $urandom, $urandom, a[NARROW-1:0], b[NARROW-1:0]);
        end
      end
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL every requirement: watchdog act=expired exp=completed");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule